// File: doc/BRIEF.md
# Coherent Wide Timestamp Counter

This block is a free-running 40-bit up-counter that software uses as a monotonic time base. It never raises an interrupt. The counter advances by one on each clock cycle in which the tick-enable input is high and counting is switched on. A separate divider produces that tick input at about 983.04 kHz; the divider is not part of this block.

Software sees the counter through a 32-bit register bus. The counter is wider than the bus, so reading it directly in two pieces could tear across a carry. To prevent this, reading the low word stores the counter's upper byte in a holding register in the same cycle. A later read of the high register returns that stored byte, so the two halves always come from one instant. Software reads the low word first, then the high word, and keeps bits 39:0 of the combined value.

The high register also carries the run enable. Software writes it to start or stop counting. A synchronous, active-high reset clears everything.

Top module: `ts_stamp_counter`

## Requirements
- R1: After reset the counter, the run enable, the holding byte, the read data and the read-valid flag are all zero.
- R2: While the run enable is 1, the counter increases by exactly one at each clock edge where `tick_en` is high. It does not change at edges where `tick_en` is low.
- R3: While the run enable is 0, the counter holds its value whatever `tick_en` does.
- R4: A write to the high register (offset 0x64) loads the run enable from write-data bit 8. All other bits of that write are ignored, and in particular the holding byte does not change.
- R5: A read of the low register (offset 0x60) returns counter bits 31:0 as they stood in the request cycle. The low register is read-only, so a write to it changes nothing.
- R6: A read of the low register copies counter bits 39:32 into the holding byte. The holding byte changes at no other time. A read of the high register returns the holding byte in bits 7:0, the run enable in bit 8, and zero in every other bit.
- R7: When a tick arrives in the same cycle as a low-register read, both the returned low word and the stored byte show the count before that tick. The tick is still counted.
- R8: After the all-ones value, the counter wraps to zero on the next counted tick.
- R9: Read data and a one-cycle `rd_valid` pulse appear on the clock edge after a read request. A read of any other offset returns zero. A write raises no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick, one cycle per time unit |
| req | input | 1 | Bus access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | High for one cycle when `rdata` holds a read result |

## Verification
The counting path is tested with runs of ticks while enabled, idle cycles without ticks, and ticks while disabled. Together these separate a counter that ignores the enable from one that ignores the tick.

Write-data patterns that set the enable bit together with junk in the byte field show whether a write to the high register leaks into the holding byte. A write to the low register shows whether that register is truly read-only.

A low read with a tick in the same cycle separates a snapshot taken before the increment from one taken after it.

A second instance with a narrow bus and counter crosses the carry into the upper field, and later the full wrap. This shows that the high read returns the stored byte rather than the live one. It also shows that the snapshot follows each carry.

// File: rtl/ts_pkg.sv
package ts_pkg;

    localparam int TS_ADDR_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_LO    = 2'd1,
        SEL_HI    = 2'd2,
        SEL_OTHER = 2'd3
    } ts_sel_e;

    typedef struct packed {
        logic    rd;
        logic    wr;
        ts_sel_e sel;
    } ts_access_t;

    function automatic ts_access_t ts_decode(
        input logic                 req,
        input logic                 we,
        input logic [TS_ADDR_W-1:0] addr,
        input logic [TS_ADDR_W-1:0] lo_ofs,
        input logic [TS_ADDR_W-1:0] hi_ofs
    );
        ts_access_t acc;
        acc.rd  = req & ~we;
        acc.wr  = req & we;
        if (!req)
            acc.sel = SEL_NONE;
        else if (addr == lo_ofs)
            acc.sel = SEL_LO;
        else if (addr == hi_ofs)
            acc.sel = SEL_HI;
        else
            acc.sel = SEL_OTHER;
        return acc;
    endfunction

endpackage

// File: rtl/ts_bus_decode.sv
module ts_bus_decode
    import ts_pkg::*;
#(
    parameter logic [TS_ADDR_W-1:0] LO_OFS = 8'h60,
    parameter logic [TS_ADDR_W-1:0] HI_OFS = 8'h64
) (
    input  logic                 req,
    input  logic                 we,
    input  logic [TS_ADDR_W-1:0] addr,
    output ts_access_t           acc
);
    always_comb begin
        acc = ts_decode(req, we, addr, LO_OFS, HI_OFS);
    end
endmodule

// File: rtl/ts_run_ctrl.sv
module ts_run_ctrl
    import ts_pkg::*;
#(
    parameter int BUS_W      = 32,
    parameter int ENABLE_BIT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ts_access_t       acc,
    input  logic [BUS_W-1:0] wdata,
    output logic             run_en
);
    logic wr_hi;

    always_comb begin
        wr_hi = acc.wr && (acc.sel == SEL_HI);
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_en <= 1'b0;
        else if (wr_hi)
            run_en <= wdata[ENABLE_BIT];
    end
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (run_en && tick_en)
            cnt <= cnt + ONE;
    end
endmodule

// File: rtl/ts_snapshot.sv
module ts_snapshot
    import ts_pkg::*;
#(
    parameter int CNT_W      = 40,
    parameter int BUS_W      = 32,
    parameter int ENABLE_BIT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ts_access_t       acc,
    input  logic [CNT_W-1:0] cnt,
    input  logic             run_en,
    output logic [CNT_W-BUS_W-1:0] hold,
    output logic [BUS_W-1:0] rdata,
    output logic             rd_valid
);
    localparam int HI_W = CNT_W - BUS_W;

    logic             rd_lo;
    logic [BUS_W-1:0] hi_word;
    logic [BUS_W-1:0] rd_next;

    always_comb begin
        rd_lo   = acc.rd && (acc.sel == SEL_LO);
        hi_word = '0;
        hi_word[HI_W-1:0]   = hold;
        hi_word[ENABLE_BIT] = run_en;
        case (acc.sel)
            SEL_LO:  rd_next = cnt[BUS_W-1:0];
            SEL_HI:  rd_next = hi_word;
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (rd_lo)
                hold <= cnt[CNT_W-1:BUS_W];
            rd_valid <= acc.rd;
            if (acc.rd)
                rdata <= rd_next;
        end
    end
endmodule

// File: rtl/ts_stamp_counter.sv
module ts_stamp_counter
    import ts_pkg::*;
#(
    parameter int                   CNT_W      = 40,
    parameter int                   BUS_W      = 32,
    parameter int                   ENABLE_BIT = 8,
    parameter logic [TS_ADDR_W-1:0] LO_OFS     = 8'h60,
    parameter logic [TS_ADDR_W-1:0] HI_OFS     = 8'h64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 req,
    input  logic                 we,
    input  logic [TS_ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]     wdata,
    output logic [BUS_W-1:0]     rdata,
    output logic                 rd_valid
);
    localparam int HI_W = CNT_W - BUS_W;

    ts_access_t       acc;
    logic             run_en;
    logic [CNT_W-1:0] cnt;
    logic [HI_W-1:0]  hold;

    ts_bus_decode #(.LO_OFS(LO_OFS), .HI_OFS(HI_OFS)) u_dec (
        .req  (req),
        .we   (we),
        .addr (addr),
        .acc  (acc)
    );

    ts_run_ctrl #(.BUS_W(BUS_W), .ENABLE_BIT(ENABLE_BIT)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .wdata  (wdata),
        .run_en (run_en)
    );

    ts_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .tick_en (tick_en),
        .cnt     (cnt)
    );

    ts_snapshot #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ENABLE_BIT(ENABLE_BIT)) u_snap (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .cnt      (cnt),
        .run_en   (run_en),
        .hold     (hold),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/ts_stamp_counter_chk.sv
module ts_stamp_counter_chk
    import ts_pkg::*;
#(
    parameter int                   CNT_W      = 40,
    parameter int                   BUS_W      = 32,
    parameter int                   ENABLE_BIT = 8,
    parameter logic [TS_ADDR_W-1:0] LO_OFS     = 8'h60,
    parameter logic [TS_ADDR_W-1:0] HI_OFS     = 8'h64
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick_en,
    input logic                    req,
    input logic                    we,
    input logic [TS_ADDR_W-1:0]    addr,
    input logic [BUS_W-1:0]        wdata,
    input logic                    rd_valid,
    input logic                    run_en,
    input logic [CNT_W-1:0]        cnt,
    input logic [CNT_W-BUS_W-1:0]  hold
);
    logic lo_rd;
    logic any_rd;
    logic hi_wr;

    always_comb begin
        lo_rd  = req && !we && (addr == LO_OFS);
        any_rd = req && !we;
        hi_wr  = req && we && (addr == HI_OFS);
    end

    // R2 and R8: one step per counted tick, wrapping modulo the width
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run_en && tick_en) |=> (cnt == $past(cnt) + 1'b1));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick_en) |=> (cnt == $past(cnt)));

    assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!run_en) |=> (cnt == $past(cnt)));

    assert_enable_load_R4: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (run_en == $past(wdata[ENABLE_BIT])));

    assert_snapshot_take_R6: assert property (@(posedge clk) disable iff (rst)
        lo_rd |=> (hold == $past(cnt[CNT_W-1:BUS_W])));

    assert_snapshot_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (!lo_rd) |=> $stable(hold));

    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        any_rd |=> rd_valid);

    assert_no_rd_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (!any_rd) |=> !rd_valid);
endmodule

bind ts_stamp_counter ts_stamp_counter_chk #(
    .CNT_W(CNT_W), .BUS_W(BUS_W), .ENABLE_BIT(ENABLE_BIT),
    .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .req      (req),
    .we       (we),
    .addr     (addr),
    .wdata    (wdata),
    .rd_valid (rd_valid),
    .run_en   (run_en),
    .cnt      (cnt),
    .hold     (hold)
);

// File: tb/sim_ts_stamp_counter.sv
module sim_ts_stamp_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick0 = 1'b0;
    logic        tick1 = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata0;
    logic [11:0] rdata1;
    logic        rv0;
    logic        rv1;

    int checks = 0;
    int fails  = 0;
    logic [31:0] r0;
    logic [11:0] r1;
    logic        v0;

    localparam logic [7:0] A_LO = 8'h60;
    localparam logic [7:0] A_HI = 8'h64;

    always #4 clk = ~clk;

    ts_stamp_counter u0 (
        .clk(clk), .rst(rst), .tick_en(tick0), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata0), .rd_valid(rv0)
    );

    ts_stamp_counter #(.CNT_W(16), .BUS_W(12), .ENABLE_BIT(8)) u1 (
        .clk(clk), .rst(rst), .tick_en(tick1), .req(req), .we(we),
        .addr(addr), .wdata(wdata[11:0]), .rdata(rdata1), .rd_valid(rv1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        v0 = rv0;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic tk);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a; tick0 = tk;
        @(posedge clk);
        @(negedge clk);
        r0 = rdata0; r1 = rdata1; v0 = rv0;
        req = 1'b0; tick0 = 1'b0;
    endtask

    task automatic ticks0(input int n);
        @(negedge clk);
        tick0 = 1'b1;
        repeat (n) @(negedge clk);
        tick0 = 1'b0;
    endtask

    task automatic ticks1(input int n);
        @(negedge clk);
        tick1 = 1'b1;
        repeat (n) @(negedge clk);
        tick1 = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 rd_valid idle", {31'b0, rv0}, 32'h0);
        check("R1 rdata idle", rdata0, 32'h0);
        bus_read(A_LO, 1'b0);
        check("R1 low word", r0, 32'h0);
        bus_read(A_HI, 1'b0);
        check("R1 high word", r0, 32'h0);
    endtask

    task automatic t_count;
        bus_write(A_HI, 32'h0000_0100);
        check("R9 no valid on write", {31'b0, v0}, 32'h0);
        ticks0(5);
        bus_read(A_LO, 1'b0);
        check("R2 five ticks", r0, 32'd5);
        check("R9 valid after read", {31'b0, v0}, 32'h1);
        repeat (3) @(negedge clk);
        bus_read(A_LO, 1'b0);
        check("R2 idle no tick", r0, 32'd5);
    endtask

    task automatic t_stop;
        bus_write(A_HI, 32'h0000_0000);
        ticks0(4);
        bus_read(A_LO, 1'b0);
        check("R3 held while off", r0, 32'd5);
        bus_read(A_HI, 1'b0);
        check("R6 high off", r0, 32'h0);
    endtask

    task automatic t_write_fields;
        bus_write(A_HI, 32'hFFFF_F1FF);
        bus_read(A_HI, 1'b0);
        check("R4 only enable bit taken", r0, 32'h0000_0100);
        bus_write(A_LO, 32'hFFFF_FFFF);
        bus_read(A_LO, 1'b0);
        check("R5 low read-only", r0, 32'd5);
    endtask

    task automatic t_same_cycle;
        bus_read(A_LO, 1'b1);
        check("R7 pre-tick snapshot", r0, 32'd5);
        bus_read(A_LO, 1'b0);
        check("R7 tick still counted", r0, 32'd6);
    endtask

    task automatic t_other;
        bus_read(8'h68, 1'b0);
        check("R9 other offset zero", r0, 32'h0);
        check("R9 other offset valid", {31'b0, v0}, 32'h1);
        bus_read(8'h00, 1'b0);
        check("R9 offset 0 zero", r0, 32'h0);
    endtask

    task automatic t_carry_wrap;
        bus_write(A_HI, 32'h0000_0100);
        ticks1(4095);
        bus_read(A_LO, 1'b0);
        check("R5 narrow low all ones", {20'h0, r1}, 32'hFFF);
        bus_read(A_HI, 1'b0);
        check("R6 narrow high before carry", {20'h0, r1}, 32'h100);
        ticks1(1);
        bus_read(A_HI, 1'b0);
        check("R6 stale byte kept", {20'h0, r1}, 32'h100);
        bus_read(A_LO, 1'b0);
        check("R6 low after carry", {20'h0, r1}, 32'h000);
        bus_read(A_HI, 1'b0);
        check("R6 byte after carry", {20'h0, r1}, 32'h101);
        ticks1(61439);
        bus_read(A_LO, 1'b0);
        check("R8 top low", {20'h0, r1}, 32'hFFF);
        bus_read(A_HI, 1'b0);
        check("R8 top high", {20'h0, r1}, 32'h10F);
        ticks1(1);
        bus_read(A_LO, 1'b0);
        check("R8 wrapped low", {20'h0, r1}, 32'h000);
        bus_read(A_HI, 1'b0);
        check("R8 wrapped high", {20'h0, r1}, 32'h100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_stop();
        t_write_fields();
        t_same_cycle();
        t_other();
        t_carry_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule